// File: doc/BRIEF.md
# Programmable Serial-Management Clock Divider

The block turns a fixed reference tick at 2500 kHz into the bit clock of a two-wire management serial link. A 7-bit configuration field holds two division settings. The first is a 4-bit coarse factor M, which divides linearly by M+1. The second is a 3-bit exponent N, which divides by 2^(N+1). The resulting clock frequency is 2500 / ((M+1) * 2^(N+1)) kHz. The settings are meant to give roughly 10 kHz to 100 kHz.

The block has two outputs. `div_clk` is the divided clock level. `edge_tick` is a one-cycle strobe that marks every change of that level, so a protocol engine can act on clock edges without running its own edge detector.

The field can be written at any time. A new value is used only from the start of the next full output period, so a change never produces a shortened high or low phase.

Top module: `mgmt_clkdiv`

## Requirements
- R1: The field layout is fixed. Bits [6:3] of `cfg_field` hold M and bits [2:0] hold N, both unsigned.
- R2: A full output period is (M+1)*2^(N+1) reference ticks. The output is low for the first (M+1)*2^N ticks of each period and high for the remaining (M+1)*2^N ticks.
- R3: While reset is asserted and directly after it is released, `div_clk` and `edge_tick` are 0. The first half-period after reset is the low half.
- R4: When the terminal reference tick of a half-period is sampled at a clock edge, `div_clk` takes its new value at that same edge.
- R5: `edge_tick` is 1 for exactly the one cycle after each edge at which `div_clk` changed, and is 0 in every other cycle.
- R6: Clock cycles in which `ref_tick` is 0 do not advance the division. The output level stays unchanged and `edge_tick` stays 0.
- R7: The settings are captured in the first cycle after reset is released. A `ref_tick` present in that cycle is not counted.
- R8: A change of `cfg_field` takes effect only at the clock edge where `div_clk` falls, which ends a full period. The field value sampled at that edge sets the length of the whole next period. Changes made earlier in the period do not alter the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle strobe at the 2500 kHz reference rate |
| cfg_field | input | 7 | Division settings: M in [6:3], N in [2:0] |
| div_clk | output | 1 | Divided clock level |
| edge_tick | output | 1 | One-cycle strobe after each change of `div_clk` |

## Verification
A linear counter that rolls over at the wrong count, or a prescaler that stops at the wrong count, shows up as a wrong half-period length at the first edge of `div_clk`. That is at most (M+1)*2^N reference ticks after reset or after a settings change. A settings register that loads at the wrong moment only becomes visible one period later, when the period in progress or the following one has the wrong length. The bench therefore keeps counting ticks across each settings change. A lost or extra strobe is visible on `edge_tick` in the same cycle as the level change it should mark.

// File: rtl/mgmt_clkdiv_pkg.sv
package mgmt_clkdiv_pkg;
  localparam int CD_M_W = 4;
  localparam int CD_N_W = 3;

  typedef struct packed {
    logic [CD_M_W-1:0] m;
    logic [CD_N_W-1:0] n;
  } cd_cfg_t;
endpackage

// File: rtl/mclk_cfg_shadow.sv
module mclk_cfg_shadow #(
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_in,
  input  logic [N_W-1:0] n_in,
  input  logic           period_end,
  output logic [M_W-1:0] m_act,
  output logic [N_W-1:0] n_act,
  output logic           primed
);
  logic load;
  assign load = !primed || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act  <= '0;
      n_act  <= '0;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (load) begin
        m_act <= m_in;
        n_act <= n_in;
      end
    end
  end

  AST_CFG_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !period_end) |=> ($stable(m_act) && $stable(n_act))); // R8
endmodule

// File: rtl/mclk_lin_stage.sv
module mclk_lin_stage #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [M_W-1:0] m_lim,
  output logic           wrap
);
  logic [M_W-1:0] lin_cnt;

  assign wrap = step && (lin_cnt == m_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_cnt <= '0;
    end else if (step) begin
      if (wrap) lin_cnt <= '0;
      else      lin_cnt <= lin_cnt + M_W'(1);
    end
  end

  AST_LIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lin_cnt <= m_lim); // R2
endmodule

// File: rtl/mclk_bin_stage.sv
module mclk_bin_stage #(
  parameter int N_W = 3,
  localparam int CNT_W = (1 << N_W) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [N_W-1:0] n_sel,
  output logic           level,
  output logic           toggle,
  output logic           falling
);
  logic [CNT_W-1:0] bin_cnt;
  logic [CNT_W-1:0] bin_lim;

  always_comb begin
    bin_lim = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(n_sel)) bin_lim[i] = 1'b1;
    end
  end

  assign toggle  = step && (bin_cnt == bin_lim);
  assign falling = toggle && level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_cnt <= '0;
      level   <= 1'b0;
    end else if (step) begin
      if (toggle) begin
        bin_cnt <= '0;
        level   <= !level;
      end else begin
        bin_cnt <= bin_cnt + CNT_W'(1);
      end
    end
  end

  AST_BIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bin_cnt <= bin_lim); // R2
  AST_LEVEL_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(level)); // R6
endmodule

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv
  import mgmt_clkdiv_pkg::*;
#(
  parameter int M_W = CD_M_W,
  parameter int N_W = CD_N_W,
  localparam int CFG_W = M_W + N_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [CFG_W-1:0] cfg_field,
  output logic             div_clk,
  output logic             edge_tick
);
  logic [M_W-1:0] m_in, m_act;
  logic [N_W-1:0] n_in, n_act;
  logic           primed, lin_wrap, level_flip, period_end, count_en;

  assign m_in = cfg_field[CFG_W-1:N_W];
  assign n_in = cfg_field[N_W-1:0];
  assign count_en = primed && ref_tick;

  mclk_cfg_shadow #(.M_W(M_W), .N_W(N_W)) i_shadow (
    .clk(clk), .rst_n(rst_n), .m_in(m_in), .n_in(n_in),
    .period_end(period_end), .m_act(m_act), .n_act(n_act), .primed(primed)
  );

  mclk_lin_stage #(.M_W(M_W)) i_lin (
    .clk(clk), .rst_n(rst_n), .step(count_en), .m_lim(m_act), .wrap(lin_wrap)
  );

  mclk_bin_stage #(.N_W(N_W)) i_bin (
    .clk(clk), .rst_n(rst_n), .step(lin_wrap), .n_sel(n_act),
    .level(div_clk), .toggle(level_flip), .falling(period_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_tick <= 1'b0;
    else        edge_tick <= level_flip;
  end

  AST_EDGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> $past(ref_tick)); // R5
  AST_LEVEL_MOVE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_clk != $past(div_clk)) |-> edge_tick); // R5
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!div_clk && !edge_tick)); // R3
endmodule

// File: tb/test_mgmt_clkdiv.sv
module test_mgmt_clkdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [6:0] cfg_field = '0;
  logic       div_clk, edge_tick;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  int half = 1;
  bit exp_lvl = 1'b0;

  always #4 clk = !clk;

  mgmt_clkdiv i_mgmt_clkdiv (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_field(cfg_field),
    .div_clk(div_clk), .edge_tick(edge_tick)
  );

  // R1/R2: half-period length from the field value
  function automatic int half_of(logic [6:0] f);
    return (int'(f[6:3]) + 1) << int'(f[2:0]);
  endfunction

  task automatic check(string req, bit lvl, bit edg);
    checks++;
    if (div_clk !== lvl || edge_tick !== edg) begin
      errors++;
      $display("FAIL %s: div_clk=%b edge_tick=%b expected %b %b", req, div_clk, edge_tick, lvl, edg);
    end
  endtask

  // Applies reset; settings are captured from cfg_field at release (R7)
  task automatic do_reset(bit tick_at_release);
    @(negedge clk);
    rst_n = 1'b0;
    ref_tick = 1'b0;
    @(negedge clk);
    check("R3", 1'b0, 1'b0);
    rst_n = 1'b1;
    ref_tick = tick_at_release;
    @(negedge clk);
    ref_tick = 1'b0;
    check("R7", 1'b0, 1'b0);
    pos = 0;
    half = half_of(cfg_field);
    exp_lvl = 1'b0;
  endtask

  // One reference tick then idle cycles; R4/R5/R8 model
  task automatic one_tick(int gap, string req);
    bit exp_edge;
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    pos++;
    exp_edge = 1'b0;
    if (pos == half) begin
      exp_lvl = 1'b1;
      exp_edge = 1'b1;
    end else if (pos == 2 * half) begin
      exp_lvl = 1'b0;
      exp_edge = 1'b1;
      pos = 0;
      half = half_of(cfg_field);
    end
    check(req, exp_lvl, exp_edge);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R6", exp_lvl, 1'b0);
    end
  endtask

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R7: fastest setting, tick at release must be ignored
    cfg_field = 7'b0000_000;
    do_reset(1'b1);
    for (int k = 0; k < 12; k++) one_tick(k % 2, "R4");
    // R1: M=2, N=1 -> half 6
    cfg_field = {4'd2, 3'd1};
    do_reset(1'b0);
    for (int k = 0; k < 30; k++) one_tick(0, "R1");
    // R8: change mid-period; current period must keep half 6
    for (int k = 0; k < 3; k++) one_tick(0, "R8");
    cfg_field = {4'd0, 3'd2};
    for (int k = 0; k < 30; k++) one_tick(1, "R8");
    // R2: largest division, full period 4096 ticks
    cfg_field = {4'd15, 3'd7};
    do_reset(1'b0);
    for (int k = 0; k < 4100; k++) one_tick(0, "R2");
    // Random settings with mid-period changes
    cfg_field = {4'd3, 3'd0};
    do_reset(1'b0);
    for (int r = 0; r < 8; r++) begin
      int n_ticks = 40 + int'($urandom_range(0, 500));
      for (int k = 0; k < n_ticks; k++) one_tick(int'($urandom_range(0, 2)), "R2");
      cfg_field = {4'($urandom_range(0, 15)), 3'($urandom_range(0, 4))};
    end
    // R6: long idle stretch holds the level
    for (int g = 0; g < 50; g++) begin
      @(negedge clk);
      check("R6", exp_lvl, 1'b0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule